// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host side of a conversion on a small multiplexed 8-bit serial converter. When a start request arrives while the block is idle, it pulls chip select low and generates a serial clock at the system clock divided by `2*CLK_DIV`. It sends a five-bit command on falling clock edges: a start bit of 1, the single-ended/differential select, the odd/sign channel bit, and two fill bits. These fill bits give the converter time to settle on the chosen input. The block then samples the returning line on rising clock edges. It skips two null bits and shifts in an 8-bit unipolar straight-binary code, MSB first. Code 0x00 means 0 V and code 0xFF means the reference minus one LSB.

There are two wiring options, chosen by a mode input that is latched at each start. In the first, the command goes out on `din_o` and the result comes back on `dout_i`. In the second, a single shared wire carries both directions. The block drives that wire through `sio_o`/`sio_oe_o` and reads it on `sio_i`. The block gives up the shared wire one system cycle after the 5th rising serial clock edge. The converter takes the wire on the 5th falling edge, so the two drivers never overlap. After the last result bit, chip select returns high and the result is presented with a one-cycle valid strobe. A new request is not accepted until chip select has stayed high for at least one full serial clock period. `CLK_DIV` must be at least 2.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the shared-line enable is low, the valid strobe is low, busy is low, and `din_o` is low.
- R2: The serial clock has a period of `2*CLK_DIV` system cycles. It is high for `CLK_DIV` cycles per pulse and gives exactly 15 rising edges per conversion. It stays low whenever chip select is high.
- R3: The command bits seen by the converter on rising edges 1 to 5 are, in order: 1, `sgl_i`, `odd_i`, 0, 0. The command line changes only on falling edges, so it is stable at each rising edge.
- R4: The bits sampled on rising edges 6 and 7 are discarded. The bits sampled on rising edges 8 to 15 form the result, MSB first, and are passed on unchanged, including the codes 0x00 and 0xFF.
- R5: `result_valid_o` is high for exactly one cycle. It coincides with chip select returning high, `30*CLK_DIV` cycles after the cycle in which the start was accepted. `result_o` holds its value until the next conversion ends.
- R6: In separate-line mode (`shared_mode_i`=0), the block samples `dout_i` and never raises `sio_oe_o`.
- R7: In shared-line mode (`shared_mode_i`=1), `sio_oe_o` is high from the start of the command through the 5th rising edge and low before the 5th falling edge. The block samples `sio_i`, and its driver never overlaps the converter's driver.
- R8: A start request is ignored while busy, and the command bits of a running conversion are not affected. Between conversions, chip select stays high for `2*CLK_DIV+1` cycles when start is held high continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled when idle |
| shared_mode_i | input | 1 | 1 = one shared data wire, 0 = separate lines |
| sgl_i | input | 1 | Single-ended/differential select bit to send |
| odd_i | input | 1 | Odd/sign channel bit to send |
| dout_i | input | 1 | Converter serial output (separate-line mode) |
| sio_i | input | 1 | Shared data wire as seen at the pin |
| busy_o | output | 1 | Conversion or turnaround gap in progress |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| din_o | output | 1 | Command line (separate-line mode) |
| sio_o | output | 1 | Value driven onto the shared wire |
| sio_oe_o | output | 1 | Tristate enable for the shared wire |
| result_valid_o | output | 1 | One-cycle result strobe |
| result_o | output | RES_W | Conversion result, unipolar straight binary |

## Verification
The bench runs a behavioural converter that latches the command on rising edges, drives the shared wire starting at the 5th falling edge, and returns a chosen code. Conversions use seeded random codes, modes and channel bits, plus directed codes 0x00, 0xFF, 0x80 and 0x01. The edge codes show whether the MSB-first ordering and the two skipped null bits are right, since an off-by-one in either would shift or corrupt them. In every conversion, a start pulse with flipped channel bits arrives mid-conversion, which shows whether requests are ignored while busy. A held-high start checks the minimum chip-select gap. Separate-line runs confirm the enable never rises, and shared-line runs check the enable at the 5th rising and falling edges and watch for overlapping drivers.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;
  // command word: start, sgl/diff, odd/sign, two fill bits
  localparam int CMD_BITS  = 5;
  // null bits returned before the result
  localparam int NULL_BITS = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_sclk_div.sv
`timescale 1ns/1ps
module adc_sclk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/adc_cmd_shift.sv
`timescale 1ns/1ps
module adc_cmd_shift #(
  parameter int CMD_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic shift,
  input  logic sgl,
  input  logic odd,
  output logic bit_o
);
  logic [CMD_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= {1'b1, sgl, odd, {(CMD_W-3){1'b0}}};
    else if (shift) sr <= {sr[CMD_W-2:0], 1'b0};
  end

  assign bit_o = sr[CMD_W-1];
endmodule

// File: rtl/adc_res_shift.sv
`timescale 1ns/1ps
module adc_res_shift #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             d,
  output logic [RES_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= {q[RES_W-2:0], d};
  end
endmodule

// File: rtl/adc_host_ctrl.sv
`timescale 1ns/1ps
module adc_host_ctrl #(
  parameter int CLK_DIV = 4,
  parameter int RES_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             shared_mode_i,
  input  logic             sgl_i,
  input  logic             odd_i,
  input  logic             dout_i,
  input  logic             sio_i,
  output logic             busy_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             din_o,
  output logic             sio_o,
  output logic             sio_oe_o,
  output logic             result_valid_o,
  output logic [RES_W-1:0] result_o
);
  import adc_host_pkg::*;

  localparam int CMD_W      = CMD_BITS;
  localparam int LAST_RISE  = CMD_W + NULL_BITS + RES_W;
  localparam int FIRST_DATA = CMD_W + NULL_BITS + 1;
  localparam int CNT_W      = $clog2(LAST_RISE + 1);
  localparam logic [CNT_W-1:0] REL_IDX  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] DATA_IDX = CNT_W'(FIRST_DATA);
  localparam logic [CNT_W-1:0] END_IDX  = CNT_W'(LAST_RISE);

  seq_state_t       state;
  logic             tick, div_en, rise_ev, fall_ev;
  logic             shared_q, rel_pend, gap_half;
  logic [CNT_W-1:0] rise_cnt, rise_nxt;
  logic             load_cmd, shift_cmd, cmd_bit, cap_en, line_in;
  logic [RES_W-1:0] shreg;

  assign div_en    = (state != ST_IDLE);
  assign rise_ev   = (state == ST_RUN) && tick && !sclk_o;
  assign fall_ev   = (state == ST_RUN) && tick &&  sclk_o;
  assign rise_nxt  = rise_cnt + 1'b1;
  assign load_cmd  = (state == ST_IDLE) && start_i;
  assign shift_cmd = fall_ev && (rise_cnt < REL_IDX);
  assign line_in   = shared_q ? sio_i : dout_i;
  assign cap_en    = rise_ev && (rise_nxt >= DATA_IDX);
  assign busy_o    = (state != ST_IDLE);
  assign din_o     = cmd_bit;
  assign sio_o     = cmd_bit;

  adc_sclk_div #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst(rst), .en(div_en), .tick(tick)
  );

  adc_cmd_shift #(.CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst(rst), .load(load_cmd), .shift(shift_cmd),
    .sgl(sgl_i), .odd(odd_i), .bit_o(cmd_bit)
  );

  adc_res_shift #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst(rst), .clr(load_cmd), .en(cap_en),
    .d(line_in), .q(shreg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      cs_n_o         <= 1'b1;
      sclk_o         <= 1'b0;
      rise_cnt       <= '0;
      shared_q       <= 1'b0;
      sio_oe_o       <= 1'b0;
      rel_pend       <= 1'b0;
      gap_half       <= 1'b0;
      result_valid_o <= 1'b0;
      result_o       <= '0;
    end else begin
      result_valid_o <= 1'b0;
      rel_pend       <= 1'b0;
      if (rel_pend) sio_oe_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            state    <= ST_RUN;
            cs_n_o   <= 1'b0;
            rise_cnt <= '0;
            shared_q <= shared_mode_i;
            sio_oe_o <= shared_mode_i;
          end
        end
        ST_RUN: begin
          if (rise_ev) begin
            sclk_o   <= 1'b1;
            rise_cnt <= rise_nxt;
            if (rise_nxt == REL_IDX) rel_pend <= shared_q;
          end else if (fall_ev) begin
            sclk_o <= 1'b0;
            if (rise_cnt == END_IDX) begin
              state          <= ST_GAP;
              cs_n_o         <= 1'b1;
              result_valid_o <= 1'b1;
              result_o       <= shreg;
              gap_half       <= 1'b0;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_half) state <= ST_IDLE;
            else          gap_half <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);
  // R3
  cmd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> $stable(din_o));
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |=> !result_valid_o);
  // R5
  valid_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> result_valid_o);
  // R6
  oe_sep_chk: assert property (@(posedge clk) disable iff (rst)
    !shared_q |-> !sio_oe_o);
  // R7
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && !sclk_o && rise_cnt >= REL_IDX) |-> !sio_oe_o);
  // R8
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |=> !$fell(cs_n_o));
endmodule

// File: tb/adc_host_ctrl_test.sv
`timescale 1ns/1ps
module adc_host_ctrl_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, mode = 1'b0, sgl = 1'b0, odd = 1'b0;
  logic busy, cs_n, sclk, din, host_sio, host_oe, valid;
  logic [7:0] result;

  logic conv_oe = 1'b0, conv_d = 1'b0;
  logic [7:0] conv_code = 8'h00;
  logic [4:0] rx = '0;
  int rcnt = 0, fcnt = 0, contention = 0;
  logic oe_r5 = 1'b0, oe_f5 = 1'b1, oe_sep_bad = 1'b0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  wire sio_line = host_oe ? host_sio : (conv_oe ? conv_d : 1'b1);
  wire to_conv  = mode ? sio_line : din;

  always #10 clk = ~clk;

  adc_host_ctrl #(.CLK_DIV(N), .RES_W(8)) uut (
    .clk(clk), .rst(rst), .start_i(start), .shared_mode_i(mode),
    .sgl_i(sgl), .odd_i(odd), .dout_i(conv_d), .sio_i(sio_line),
    .busy_o(busy), .cs_n_o(cs_n), .sclk_o(sclk), .din_o(din),
    .sio_o(host_sio), .sio_oe_o(host_oe), .result_valid_o(valid),
    .result_o(result)
  );

  // behavioural converter
  always @(negedge cs_n) begin rcnt = 0; fcnt = 0; end
  always @(posedge cs_n) conv_oe <= 1'b0;
  always @(posedge sclk) begin
    rcnt = rcnt + 1;
    if (rcnt <= 5) rx[5-rcnt] = to_conv;
    if (rcnt == 5) oe_r5 = host_oe;
    if (rcnt == 6) conv_d <= 1'b0;
    if (rcnt >= 7 && rcnt <= 14) conv_d <= conv_code[14-rcnt];
  end
  always @(negedge sclk) begin
    fcnt = fcnt + 1;
    if (fcnt == 5) begin
      oe_f5 = host_oe;
      conv_oe <= 1'b1;
      conv_d  <= 1'b0;
    end
  end
  always @(posedge clk) begin
    if (host_oe && conv_oe) contention <= contention + 1;
    if (!mode && host_oe) oe_sep_bad <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_cmd(input logic s, input logic o);
    return {1'b1, s, o, 2'b00};
  endfunction

  task automatic do_conv(input logic md, input logic s, input logic o, input logic [7:0] code);
    int m, hi, cbase;
    @(negedge clk);
    mode = md; sgl = s; odd = o; conv_code = code; start = 1'b1;
    cbase = contention; oe_sep_bad = 1'b0;
    m = 0; hi = 0;
    while (!valid && m < 2000) begin
      @(negedge clk);
      m++;
      if (sclk) hi++;
      if (m == 1) start = 1'b0;
      if (m == 40) begin start = 1'b1; sgl = ~s; odd = ~o; end  // R8 mid-run request
      if (m == 41) start = 1'b0;
    end
    chk(valid, "R5 valid seen", valid, 1);
    chk(m == 30*N+1, "R5 latency", m, 30*N+1);
    chk(result == code, "R4 result", result, code);
    chk(rx == exp_cmd(s, o), "R3/R8 command bits", rx, exp_cmd(s, o));
    chk(rcnt == 15, "R2 rising edges", rcnt, 15);
    chk(hi == 15*N, "R2 high time", hi, 15*N);
    if (md) begin
      chk(oe_r5 == 1'b1, "R7 oe at rise5", oe_r5, 1);
      chk(oe_f5 == 1'b0, "R7 oe at fall5", oe_f5, 0);
      chk(contention == cbase, "R7 contention", contention - cbase, 0);
    end else begin
      chk(!oe_sep_bad, "R6 oe stays low", oe_sep_bad, 0);
    end
    @(negedge clk);
    chk(!valid, "R5 one-cycle strobe", valid, 0);
    chk(result == code, "R5 result held", result, code);
    sgl = s; odd = o;
    repeat (2*N + 2) @(negedge clk);
    chk(!busy, "R8 idle after gap", busy, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int g;
    logic [7:0] c1, c2;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(host_oe == 1'b0, "R1 oe", host_oe, 0);
    chk(valid == 1'b0, "R1 valid", valid, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(din == 1'b0, "R1 din", din, 0);

    // directed unipolar corner codes in both wirings
    do_conv(1'b0, 1'b1, 1'b0, 8'h00);
    do_conv(1'b0, 1'b0, 1'b1, 8'hFF);
    do_conv(1'b1, 1'b1, 1'b1, 8'h00);
    do_conv(1'b1, 1'b0, 1'b0, 8'hFF);
    do_conv(1'b1, 1'b1, 1'b0, 8'h80);
    do_conv(1'b0, 1'b0, 1'b0, 8'h01);

    // random conversions
    for (int i = 0; i < 24; i++) begin
      do_conv(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
    end

    // R8 gap with start held high continuously
    c1 = 8'h5A; c2 = 8'hC3;
    @(negedge clk);
    mode = 1'b1; sgl = 1'b1; odd = 1'b0; conv_code = c1; start = 1'b1;
    while (!valid) @(negedge clk);
    chk(result == c1, "R8 first result", result, c1);
    conv_code = c2; sgl = 1'b0; odd = 1'b1;
    g = 0;
    while (cs_n && g < 100) begin g++; @(negedge clk); end
    chk(g == 2*N+1, "R8 cs_n gap", g, 2*N+1);
    start = 1'b0;
    while (!valid) @(negedge clk);
    chk(result == c2, "R8 second result", result, c2);
    chk(rx == exp_cmd(1'b0, 1'b1), "R8 second command", rx, exp_cmd(1'b0, 1'b1));
    repeat (2*N + 2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule